// File: doc/BRIEF.md
# Packet Receive Buffer with Acknowledge Gating

This block sits between a network receive front end and a slower downstream consumer such as a flash programming engine. The front end delivers each packet payload as a byte stream. Every beat carries a valid strobe, and markers for the first and last byte. A packet-good flag is presented with the last byte. Bytes are buffered in a 512-entry byte FIFO. A packet's bytes only become visible to the consumer when the packet ends with the good flag set. If the flag is clear, the bytes are thrown away.

For each packet the block makes one acknowledgement decision. It raises a single-cycle acknowledge request, which the host-side logic turns into a reply frame. The request is only raised for a good packet, and only while the buffer holds fewer than half its capacity in committed bytes. The host waits for this acknowledgement before sending its next packet, so withholding it slows the sender down. An acknowledgement that was held back only because of the half-full condition is raised later, once the consumer drains the buffer below half.

Top module: `rxfifo_ackgate`

## Requirements
- R1: After reset, rd_valid, half_full, overflow and ack_req are all low.
- R2: The read port is first-word-fall-through. rd_valid is high whenever committed bytes are held. rd_data shows the oldest committed byte. A read with rd_en high pops it, and bytes leave in arrival order.
- R3: When a beat with in_valid, in_eop and in_good high is taken at a clock edge, ack_req is high for exactly the following cycle, provided half_full is low in that cycle.
- R4: A packet whose last beat has in_good low never produces an acknowledgement. None of its bytes ever reach the read port.
- R5: half_full is high exactly when the count of committed, unread bytes is 256 (DEPTH/2) or more.
- R6: While half_full is high, ack_req stays low. If a good packet's acknowledgement was held back by half_full, ack_req pulses for one cycle in the first cycle half_full is low again. Any number of held-back packets yields a single such pulse.
- R7: A write beat that arrives when the buffer already stores DEPTH bytes is dropped. The count of stored bytes includes unfinished packet bytes. The dropped beat sets overflow, which stays high until reset.
- R8: A start-of-packet beat that arrives before the previous packet ended discards that unfinished packet's bytes. The new packet is then written in their place.
- R9: Bytes of a packet in progress do not appear at the read port before its end beat is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Payload byte present this cycle |
| in_sop | input | 1 | Beat is the first byte of a packet |
| in_eop | input | 1 | Beat is the last byte of a packet |
| in_good | input | 1 | Packet check result, sampled with in_eop |
| in_data | input | 8 | Payload byte |
| rd_en | input | 1 | Consumer pops the oldest byte |
| rd_data | output | 8 | Oldest committed byte |
| rd_valid | output | 1 | At least one committed byte is held |
| half_full | output | 1 | Committed occupancy at or above half |
| overflow | output | 1 | Sticky flag: a byte was dropped on full |
| ack_req | output | 1 | Single-cycle request to acknowledge the host |

## Verification
Several properties are checked on every cycle by the assertions. No acknowledge is raised while half_full is high. A bad packet's decision cycle never acknowledges. A bad end beat restores the write pointer to the committed one. The committed pointer moves only on end beats. Occupancy never exceeds the depth, and the overflow flag never falls. Other behaviour can only be shown by the bench's scenarios, which drive a reference model in lockstep with the design. These are the byte order across many mixed good and bad packets, the exact cycle of each acknowledge pulse, the single late pulse after a fill-and-drain, and the abandonment of a packet cut short by a new start marker.

// File: rtl/rxfifo_pkg.sv
package rxfifo_pkg;
  localparam int unsigned RXF_DEPTH  = 512;
  localparam int unsigned RXF_DATA_W = 8;

  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,
    DEC_GOOD = 2'd1,
    DEC_BAD  = 2'd2
  } rxf_dec_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/rxf_ptrs.sv
module rxf_ptrs #(
  parameter int unsigned DEPTH = 512,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic          in_good,
  input  logic          rd_en,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          half_full,
  output logic          overflow,
  output logic          end_beat
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  logic [PW-1:0] wsp_q, wsp_d;
  logic [PW-1:0] wcm_q, wcm_d;
  logic [PW-1:0] rd_q, rd_d;
  logic          ovf_q, ovf_d;
  logic [PW-1:0] base, after_wr, spec_cnt, cmt_cnt;
  logic          full, rd_fire;

  always_comb begin
    base      = in_sop ? wcm_q : wsp_q;
    spec_cnt  = base - rd_q;
    full      = (spec_cnt == DEPTH_P);
    cmt_cnt   = wcm_q - rd_q;
    rd_valid  = (cmt_cnt != '0);
    half_full = (cmt_cnt >= HALF_P);
    rd_fire   = rd_en & rd_valid;
    wr_en     = in_valid & ~full;
    wr_addr   = base[AW-1:0];
    rd_addr   = rd_q[AW-1:0];
    end_beat  = in_valid & in_eop;
    after_wr  = wr_en ? base + PW'(1) : base;
    wsp_d     = in_valid ? after_wr : wsp_q;
    wcm_d     = wcm_q;
    if (end_beat) begin
      if (in_good) begin
        wcm_d = after_wr;
        wsp_d = after_wr;
      end else begin
        wsp_d = wcm_q;
      end
    end
    rd_d  = rd_q + PW'(1);
    ovf_d = ovf_q | (in_valid & full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsp_q <= '0;
      wcm_q <= '0;
      rd_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (in_valid) wsp_q <= wsp_d;
      if (end_beat) wcm_q <= wcm_d;
      if (rd_fire)  rd_q  <= rd_d;
      ovf_q <= ovf_d;
    end
  end

  assign overflow = ovf_q;

  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);
  a_r7_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full) |=> ovf_q);
  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (wsp_q - rd_q) <= DEPTH_P);
  a_r4_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_eop && !in_good) |=> (wsp_q == wcm_q));
  a_r9_commit_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_eop) |=> $stable(wcm_q));
  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(rd_q));
endmodule

// File: rtl/rxf_ack.sv
module rxf_ack
  import rxfifo_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic end_beat,
  input  logic good,
  input  logic half_full,
  output logic ack_req
);
  rxf_dec_e dec_q, dec_d;
  logic     wait_q, wait_d;
  logic     want;

  always_comb begin
    if (end_beat) dec_d = good ? DEC_GOOD : DEC_BAD;
    else          dec_d = DEC_NONE;
    want    = (dec_q == DEC_GOOD) | wait_q;
    ack_req = want & ~half_full;
    wait_d  = want & half_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= DEC_NONE;
      wait_q <= 1'b0;
    end else begin
      dec_q  <= dec_d;
      wait_q <= wait_d;
    end
  end

  a_r6_quiet_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    half_full |-> !ack_req);
  a_r4_bad_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q == DEC_BAD && !wait_q) |-> !ack_req);
  a_r6_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !half_full) |=> !wait_q);
  a_r3_good_decides: assert property (@(posedge clk) disable iff (!rst_n)
    (end_beat && good) |=> (ack_req || wait_q || half_full));
endmodule

// File: rtl/rxfifo_ackgate.sv
module rxfifo_ackgate
  import rxfifo_pkg::*;
#(
  parameter int unsigned DEPTH  = RXF_DEPTH,
  parameter int unsigned DATA_W = RXF_DATA_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_good,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              half_full,
  output logic              overflow,
  output logic              ack_req
);
  logic          wr_en, end_beat;
  logic [AW-1:0] wr_addr, rd_addr;

  rxf_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_good(in_good), .rd_en(rd_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .half_full(half_full), .overflow(overflow), .end_beat(end_beat)
  );

  rxf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  rxf_ack ack_i (
    .clk(clk), .rst_n(rst_n), .end_beat(end_beat), .good(in_good),
    .half_full(half_full), .ack_req(ack_req)
  );
endmodule

// File: tb/rxfifo_ackgate_tb_top.sv
module rxfifo_ackgate_tb_top;
  localparam int DEPTH = 512;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_sop, in_eop, in_good, rd_en;
  logic [7:0] in_data, rd_data;
  logic       rd_valid, half_full, overflow, ack_req;

  always #5 clk = ~clk;

  rxfifo_ackgate dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_good(in_good), .in_data(in_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .half_full(half_full),
    .overflow(overflow), .ack_req(ack_req)
  );

  int checks = 0, fails = 0, reads = 0, acks = 0;
  bit done = 0;
  logic [7:0] m_cmt[$];
  logic [7:0] m_spec[$];
  bit m_dec = 0, m_good = 0, m_wait = 0, m_ovf = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_ack();
    return (m_cmt.size() < HALF) && ((m_dec && m_good) || m_wait);
  endfunction

  function automatic string ack_tag();
    if (m_wait) return "R6";
    if (m_dec && !m_good) return "R4";
    return "R3";
  endfunction

  task automatic compare();
    chk(ack_req == exp_ack(), ack_tag(), "ack_req", int'(ack_req), int'(exp_ack()));
    chk(half_full == (m_cmt.size() >= HALF), "R5", "half_full",
        int'(half_full), int'(m_cmt.size() >= HALF));
    chk(rd_valid == (m_cmt.size() > 0), "R2", "rd_valid",
        int'(rd_valid), int'(m_cmt.size() > 0));
    if (m_cmt.size() > 0)
      chk(rd_data == m_cmt[0], "R2", "rd_data", int'(rd_data), int'(m_cmt[0]));
    chk(overflow == m_ovf, "R7", "overflow", int'(overflow), int'(m_ovf));
    if (rd_en && rd_valid) reads++;
    if (ack_req) acks++;
  endtask

  task automatic update_model();
    bit h  = m_cmt.size() >= HALF;
    bit nw = ((m_dec && m_good) || m_wait) && h;
    int c_pre = m_cmt.size();
    if (in_valid) begin
      if (in_sop) m_spec.delete();
      if (c_pre + m_spec.size() >= DEPTH) m_ovf = 1;
      else m_spec.push_back(in_data);
    end
    if (rd_en && c_pre > 0) void'(m_cmt.pop_front());
    if (in_valid && in_eop) begin
      m_dec = 1; m_good = in_good;
      if (in_good) foreach (m_spec[i]) m_cmt.push_back(m_spec[i]);
      m_spec.delete();
    end else begin
      m_dec = 0;
    end
    m_wait = nw;
  endtask

  task automatic tick();
    #1;
    compare();
    @(posedge clk);
    update_model();
    @(negedge clk);
  endtask

  task automatic idle(input int n, input int rd_prob);
    for (int i = 0; i < n; i++) begin
      in_valid = 0; in_sop = 0; in_eop = 0; in_good = 0;
      rd_en = ($urandom % 100) < rd_prob;
      tick();
    end
  endtask

  task automatic send_bytes(input int len, input bit sop, input bit eop,
                            input bit good, input int rd_prob);
    for (int i = 0; i < len; i++) begin
      in_valid = 1;
      in_sop   = sop && (i == 0);
      in_eop   = eop && (i == len - 1);
      in_good  = good && in_eop;
      in_data  = 8'($urandom);
      rd_en    = ($urandom % 100) < rd_prob;
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; in_valid = 0; in_sop = 0; in_eop = 0; in_good = 0;
    in_data = 0; rd_en = 0;
    repeat (3) @(negedge clk);
    chk(!rd_valid && !half_full && !overflow && !ack_req, "R1", "reset outputs",
        int'({rd_valid, half_full, overflow, ack_req}), 0);
    rst_n = 1;
    idle(2, 0);

    // R9: unfinished packet stays invisible
    send_bytes(3, 1, 0, 0, 0);
    #1 chk(!rd_valid, "R9", "rd_valid mid-packet", int'(rd_valid), 0);
    // R8: restart with new start marker, then drain and count bytes
    send_bytes(2, 1, 1, 1, 0);
    reads = 0;
    idle(6, 100);
    chk(reads == 2, "R8", "bytes after restart", reads, 2);

    // R4: bad packet yields nothing readable
    send_bytes(5, 1, 1, 0, 0);
    idle(1, 0);
    #1 chk(!rd_valid, "R4", "rd_valid after bad packet", int'(rd_valid), 0);
    idle(2, 100);

    // random mix of packets and reader rates
    for (int p = 0; p < 300; p++) begin
      send_bytes(1 + int'($urandom % 40), 1, 1, ($urandom % 100) < 85,
                 60 + int'($urandom % 41));
      idle(int'($urandom % 6), 80);
    end
    idle(200, 100);

    // fill past half and to full with the reader stopped
    for (int p = 0; p < 18; p++) begin
      send_bytes(32, 1, 1, 1, 0);
      idle(1, 0);
    end
    send_bytes(4, 1, 1, 0, 0);
    #1 chk(half_full == 1, "R5", "half_full when filled", int'(half_full), 1);
    chk(overflow == 1, "R7", "overflow after fill", int'(overflow), 1);
    acks = 0;
    idle(DEPTH + 20, 100);
    chk(acks == 1, "R6", "late ack pulses after drain", acks, 1);
    chk(overflow == 1 && !rd_valid, "R7", "overflow sticky, drained",
        int'({overflow, rd_valid}), 2);

    // small random tail
    for (int p = 0; p < 40; p++) begin
      send_bytes(1 + int'($urandom % 16), 1, 1, ($urandom % 2) == 0, 90);
      idle(int'($urandom % 3), 90);
    end
    idle(60, 100);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule